// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

This block moves data words from a producer clock domain to a consumer clock domain through a small memory of 2^AW entries. Each side has its own clock, a stream handshake and a qualifying clock enable. A word enters on a `wr_clk` edge only when `wr_valid`, `wr_ce` and `wr_ready` are all high. A word leaves on an `rd_clk` edge only when `rd_ready`, `rd_ce` and `rd_valid` are all high. The read side runs in show-ahead mode: `rd_data` holds the oldest stored word whenever `rd_valid` is high. A producer facing back-pressure must hold its word and `wr_valid` until a cycle in which `wr_ready` is high. A consumer may hold `rd_ready` or `rd_ce` low for as long as it likes, and the head word stays in place.

The write side has two level indications, full (shown as `wr_ready` low) and almost-full. The read side has two as well, empty (shown as `rd_valid` low) and almost-empty. The full, almost-full and almost-empty limits are programmable. Empty means a level of zero. Each flag is a register clocked in its own domain. Each side builds its level from its own binary pointer and the other side's pointer, which crosses the domain as a Gray code through a two-flop synchronizer.

Two resets are provided. `arst_n` clears both pointers and all flags. `rd_rewind` moves only the read pointer back to entry zero, so everything written since the last global reset can be read out again. The write side then sees its level rise again.

Top module: `af_retx_fifo`

## Requirements
- R1: A word is stored only on a `wr_clk` edge where `wr_valid`, `wr_ce` and `wr_ready` are all 1. With `wr_valid`=1 and `wr_ce`=0, or with `wr_valid`=0, nothing is stored and `rd_valid` stays 0 on an empty FIFO.
- R2: A word is removed only on an `rd_clk` edge where `rd_ready`, `rd_ce` and `rd_valid` are all 1. While `rd_valid` is 1 and no removal takes place, `rd_data` keeps the same head word. The read pointer advances by at most one per edge.
- R3: Words leave in exactly the order in which they were accepted.
- R4: `wr_ready` is 0 in the `wr_clk` cycle after the write-side level reaches `cfg_full_lvl` (1 to 2^AW-1). A write attempted while `wr_ready` is 0 is dropped and does not move the write pointer.
- R5: `wr_afull` is 1 exactly when the write-side level is at least `cfg_afull_lvl` (1 to `cfg_full_lvl`-1). It is registered on `wr_clk`.
- R6: `rd_valid` is 0 exactly when the read-side level is zero. A read attempted while it is 0 is dropped and does not move the read pointer.
- R7: `rd_aempty` is 1 exactly when the read-side level is at most `cfg_aempty_lvl` (1 to `cfg_full_lvl`-1). It is registered on `rd_clk`.
- R8: While `arst_n` is low, and after it rises until the first transfer, the outputs are `wr_ready`=1, `wr_afull`=0, `rd_valid`=0 and `rd_aempty`=1.
- R9: A one-cycle pulse of `rd_rewind` returns the read pointer to entry zero, and the words written since the last global reset are delivered again in their original order. This holds when fewer than 2^AW words have been written since that reset and the write port stays idle until the flags settle.
- R10: After a rewind, the write side recomputes its level from the restored read pointer, so `wr_ready` can fall and `wr_afull` can rise again.
- R11: Each pointer crosses domains as a Gray code that changes by at most one bit per edge, outside a rewind. A write into an empty FIFO raises `rd_valid` within four `rd_clk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock |
| arst_n | input | 1 | Global asynchronous reset, active low, for both domains |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ce | input | 1 | Write clock enable; qualifies `wr_valid` |
| wr_data | input | DW | Word to store |
| wr_ready | output | 1 | Space available (low means full) |
| wr_afull | output | 1 | Write-side level at or above `cfg_afull_lvl` |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_ce | input | 1 | Read clock enable; qualifies `rd_ready` |
| rd_rewind | input | 1 | Return the read pointer to entry zero (rd_clk domain) |
| rd_valid | output | 1 | Head word present (low means empty) |
| rd_data | output | DW | Head word |
| rd_aempty | output | 1 | Read-side level at or below `cfg_aempty_lvl` |
| cfg_full_lvl | input | AW | Full limit in entries |
| cfg_afull_lvl | input | AW | Almost-full limit in entries |
| cfg_aempty_lvl | input | AW | Almost-empty limit in entries |

## Verification
The assertions check four things on every edge of each clock. A blocked write or read leaves its pointer where it was. The read pointer only holds, steps by one or returns home on a rewind. The Gray pointer handed to the other domain never flips more than one bit. The write side never sees more than 2^AW entries outstanding. Data ordering, the exact cycle at which each flag tracks the level, the dropping of writes without clock enable, the replay after a rewind with the full flag coming back, and the crossing latency can only be shown by the bench. It does so with directed fill, drain and rewind sequences, and with seeded random traffic on both clocks against a queue model.

// File: rtl/af_pkg.sv
package af_pkg;

  // Stages in each pointer synchronizer.
  localparam int unsigned AF_SYNC_STAGES = 2;

  // Flag pair of one side: lim is the hard limit (full or empty),
  // near is the programmable warning (almost-full or almost-empty).
  typedef struct packed {
    logic lim;
    logic near;
  } af_flag_t;

endpackage

// File: rtl/af_gray_cvt.sv
module af_gray_cvt #(
  parameter int W = 5
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);

  assign gray_o = bin_i ^ (bin_i >> 1);

  // Each binary bit is the parity of the Gray bits at and above it.
  for (genvar i = 0; i < W; i++) begin : g_fold
    assign bin_o[i] = ^gray_i[W-1:i];
  end

endmodule

// File: rtl/af_sync.sv
module af_sync #(
  parameter int W      = 5,
  parameter int STAGES = af_pkg::AF_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[0] <= '0;
        else         stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/af_mem.sv
module af_mem #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  // Show-ahead: the entry under the read pointer is always on the output.
  assign rdata = cells[raddr];

endmodule

// File: rtl/af_wr_side.sv
module af_wr_side import af_pkg::*; #(
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          push_req,
  input  logic [AW-1:0] cfg_full,
  input  logic [AW-1:0] cfg_afull,
  input  logic [PW-1:0] rgray_s,
  output logic          push,
  output logic [AW-1:0] addr,
  output logic [PW-1:0] gray,
  output af_flag_t      flg
);

  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, wgray_nxt, rbin_s, lvl_nxt, lvl_now;
  af_flag_t      flg_q, flg_nxt;

  assign push     = push_req & ~flg_q.lim;
  assign wbin_nxt = wbin_q + PW'(push);

  af_gray_cvt #(.W(PW)) u_cvt (
    .bin_i  (wbin_nxt),
    .gray_o (wgray_nxt),
    .gray_i (rgray_s),
    .bin_o  (rbin_s)
  );

  // Flags are formed from the level after this edge so they are exact
  // for the next write decision.
  assign lvl_nxt = wbin_nxt - rbin_s;
  assign lvl_now = wbin_q - rbin_s;

  always_comb begin
    flg_nxt.lim  = (lvl_nxt >= {1'b0, cfg_full});
    flg_nxt.near = (lvl_nxt >= {1'b0, cfg_afull});
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      flg_q   <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wgray_nxt;
      flg_q   <= flg_nxt;
    end
  end

  assign addr = wbin_q[AW-1:0];
  assign gray = wgray_q;
  assign flg  = flg_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
    (flg_q.lim && push_req) |=> $stable(wbin_q)); // R4
  AST_WGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(wgray_q ^ $past(wgray_q))); // R11
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    lvl_now <= DEPTH_P); // R4

endmodule

// File: rtl/af_rd_side.sv
module af_rd_side import af_pkg::*; #(
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          pop_req,
  input  logic          rewind,
  input  logic [AW-1:0] cfg_aempty,
  input  logic [PW-1:0] wgray_s,
  output logic          pop,
  output logic [AW-1:0] addr,
  output logic [PW-1:0] gray,
  output af_flag_t      flg
);

  localparam logic [PW-1:0] ONE_P = PW'(1);

  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, rgray_nxt, wbin_s, lvl_nxt;
  af_flag_t      flg_q, flg_nxt;

  assign pop = pop_req & ~flg_q.lim;

  // A rewind overrides any read in the same cycle.
  assign rbin_nxt = rewind ? '0 : (rbin_q + PW'(pop));

  af_gray_cvt #(.W(PW)) u_cvt (
    .bin_i  (rbin_nxt),
    .gray_o (rgray_nxt),
    .gray_i (wgray_s),
    .bin_o  (wbin_s)
  );

  assign lvl_nxt = wbin_s - rbin_nxt;

  always_comb begin
    flg_nxt.lim  = (lvl_nxt == '0);
    flg_nxt.near = (lvl_nxt <= {1'b0, cfg_aempty});
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      flg_q   <= '{lim: 1'b1, near: 1'b1};
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rgray_nxt;
      flg_q   <= flg_nxt;
    end
  end

  assign addr = rbin_q[AW-1:0];
  assign gray = rgray_q;
  assign flg  = flg_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
    (flg_q.lim && pop_req && !rewind) |=> $stable(rbin_q)); // R6
  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    !rewind |=> (rbin_q == $past(rbin_q) || rbin_q == $past(rbin_q) + ONE_P)); // R2
  AST_REWIND_HOME: assert property (@(posedge clk) disable iff (!arst_n)
    rewind |=> (rbin_q == '0)); // R9

endmodule

// File: rtl/af_retx_fifo.sv
module af_retx_fifo import af_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          arst_n,
  input  logic          wr_valid,
  input  logic          wr_ce,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          wr_afull,
  input  logic          rd_ready,
  input  logic          rd_ce,
  input  logic          rd_rewind,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_aempty,
  input  logic [AW-1:0] cfg_full_lvl,
  input  logic [AW-1:0] cfg_afull_lvl,
  input  logic [AW-1:0] cfg_aempty_lvl
);

  logic          push, pop;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  af_flag_t      wflg, rflg;

  af_wr_side #(.AW(AW)) u_wr (
    .clk       (wr_clk),
    .arst_n    (arst_n),
    .push_req  (wr_valid & wr_ce),
    .cfg_full  (cfg_full_lvl),
    .cfg_afull (cfg_afull_lvl),
    .rgray_s   (rgray_s),
    .push      (push),
    .addr      (waddr),
    .gray      (wgray),
    .flg       (wflg)
  );

  af_rd_side #(.AW(AW)) u_rd (
    .clk        (rd_clk),
    .arst_n     (arst_n),
    .pop_req    (rd_ready & rd_ce),
    .rewind     (rd_rewind),
    .cfg_aempty (cfg_aempty_lvl),
    .wgray_s    (wgray_s),
    .pop        (pop),
    .addr       (raddr),
    .gray       (rgray),
    .flg        (rflg)
  );

  af_sync #(.W(PW)) u_w2r (
    .clk    (rd_clk),
    .arst_n (arst_n),
    .d      (wgray),
    .q      (wgray_s)
  );

  af_sync #(.W(PW)) u_r2w (
    .clk    (wr_clk),
    .arst_n (arst_n),
    .d      (rgray),
    .q      (rgray_s)
  );

  af_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk  (wr_clk),
    .we    (push),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );

  assign wr_ready  = ~wflg.lim;
  assign wr_afull  = wflg.near;
  assign rd_valid  = ~rflg.lim;
  assign rd_aempty = rflg.near;

  AST_POP_NEEDS_DATA: assert property (@(posedge rd_clk) disable iff (!arst_n)
    pop |-> rd_valid); // R6

endmodule

// File: tb/sim_af_retx_fifo.sv
`timescale 1ns/1ps
module sim_af_retx_fifo;
  localparam int DW = 8;
  localparam int AW = 4;

  logic wr_clk = 1'b0, rd_clk = 1'b0, arst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ce = 1'b0, rd_ready = 1'b0, rd_ce = 1'b0, rd_rewind = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] cfg_full_lvl = AW'(10), cfg_afull_lvl = AW'(7), cfg_aempty_lvl = AW'(3);
  logic wr_ready, wr_afull, rd_valid, rd_aempty;
  logic [DW-1:0] rd_data;

  always #10 wr_clk = ~wr_clk;
  always #13 rd_clk = ~rd_clk;

  af_retx_fifo #(.DW(DW), .AW(AW)) u0 (
    .wr_clk, .rd_clk, .arst_n, .wr_valid, .wr_ce, .wr_data, .wr_ready, .wr_afull,
    .rd_ready, .rd_ce, .rd_rewind, .rd_valid, .rd_data, .rd_aempty,
    .cfg_full_lvl, .cfg_afull_lvl, .cfg_aempty_lvl
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] hist[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_wr(input logic v, input logic ce, input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_valid = v; wr_ce = ce; wr_data = d;
    if (v && ce && wr_ready) begin
      mq.push_back(d);
      hist.push_back(d);
    end
  endtask

  task automatic do_rd(input logic rdy, input logic ce, input string req);
    @(negedge rd_clk);
    rd_ready = rdy; rd_ce = ce;
    if (rdy && ce && rd_valid) begin
      if (mq.size() == 0) chk(req, 32'(rd_data), 32'hdead);
      else chk(req, 32'(rd_data), 32'(mq.pop_front()));
    end
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    arst_n = 1'b0; wr_valid = 1'b0; wr_ce = 1'b0; rd_ready = 1'b0; rd_ce = 1'b0; rd_rewind = 1'b0;
    mq.delete(); hist.delete();
    repeat (3) @(negedge wr_clk);
    arst_n = 1'b1;
    repeat (2) @(negedge rd_clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    int lag;
    void'($urandom(32'd2024));

    // R8: reset values
    repeat (3) @(negedge wr_clk);
    chk("R8 wr_ready in reset", 32'(wr_ready), 1);
    chk("R8 rd_valid in reset", 32'(rd_valid), 0);
    arst_n = 1'b1;
    @(negedge rd_clk);
    chk("R8 wr_afull", 32'(wr_afull), 0);
    chk("R8 rd_aempty", 32'(rd_aempty), 1);

    // R1: offers without clock enable, or enable without valid, store nothing
    repeat (3) do_wr(1'b1, 1'b0, 8'h55);
    repeat (2) do_wr(1'b0, 1'b1, 8'h66);
    do_wr(1'b0, 1'b0, 8'h00);
    repeat (6) @(negedge rd_clk);
    chk("R1 no store without enable", 32'(rd_valid), 0);

    // R4/R5: fill with limit 10, almost-full 7, reader idle
    cnt = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge wr_clk);
      chk("R5 wr_afull during fill", 32'(wr_afull), 32'(cnt >= 7));
      chk("R4 wr_ready during fill", 32'(wr_ready), 32'(cnt < 10));
      wr_valid = 1'b1; wr_ce = 1'b1; wr_data = 8'hA0 + 8'(i);
      if (wr_ready) begin
        cnt++;
        mq.push_back(wr_data);
        hist.push_back(wr_data);
      end
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
    chk("R4 accepted count", 32'(cnt), 10);

    // R6/R7 before draining
    repeat (5) @(negedge rd_clk);
    chk("R6 rd_valid filled", 32'(rd_valid), 1);
    chk("R7 rd_aempty filled", 32'(rd_aempty), 0);

    // R2: head holds while the read enable is off
    for (int i = 0; i < 3; i++) begin
      do_rd(1'b1, 1'b0, "R2");
      chk("R2 head held", 32'(rd_data), 32'(mq[0]));
    end

    // R3/R6/R7: drain with exact flags
    for (int i = 0; i < 12; i++) begin
      @(negedge rd_clk);
      chk("R7 rd_aempty drain", 32'(rd_aempty), 32'(mq.size() <= 3));
      chk("R6 rd_valid drain", 32'(rd_valid), 32'(mq.size() > 0));
      rd_ready = 1'b1; rd_ce = 1'b1;
      if (rd_valid) chk("R3 order", 32'(rd_data), 32'(mq.pop_front()));
    end
    @(negedge rd_clk);
    rd_ready = 1'b0;
    repeat (5) @(negedge wr_clk);
    chk("R4 wr_ready after drain", 32'(wr_ready), 1);

    // R9/R10: rewind replays and refills the write side
    @(negedge rd_clk); rd_rewind = 1'b1;
    @(negedge rd_clk); rd_rewind = 1'b0;
    foreach (hist[k]) mq.push_back(hist[k]);
    repeat (6) @(negedge wr_clk);
    chk("R10 wr_ready after rewind", 32'(wr_ready), 0);
    chk("R10 wr_afull after rewind", 32'(wr_afull), 1);
    @(negedge rd_clk);
    chk("R9 rd_valid after rewind", 32'(rd_valid), 1);
    for (int i = 0; i < 10; i++) do_rd(1'b1, 1'b1, "R9 replay");
    do_rd(1'b0, 1'b0, "R9");
    chk("R9 replay count", 32'(mq.size()), 0);
    repeat (6) @(negedge wr_clk);
    chk("R10 wr_ready after replay", 32'(wr_ready), 1);

    // R11: crossing latency into an empty FIFO
    do_reset();
    chk("R8 after second reset", 32'({wr_ready, wr_afull, rd_valid, rd_aempty}), 32'b1001);
    do_wr(1'b1, 1'b1, 8'h3C);
    do_wr(1'b0, 1'b0, 8'h00);
    lag = 0;
    while (!rd_valid && lag < 8) begin
      @(negedge rd_clk);
      lag++;
    end
    chk("R11 empty-to-valid within 4 reads", 32'(lag <= 4), 1);
    do_rd(1'b1, 1'b1, "R11 data");
    do_rd(1'b0, 1'b0, "R11");

    // Random traffic with random limits
    for (int r = 0; r < 4; r++) begin
      int fl, afl, ael;
      fl  = 2 + int'($urandom % 14);
      afl = 1 + int'($urandom % (fl - 1));
      ael = 1 + int'($urandom % (fl - 1));
      cfg_full_lvl = AW'(fl); cfg_afull_lvl = AW'(afl); cfg_aempty_lvl = AW'(ael);
      do_reset();
      fork
        begin
          for (int i = 0; i < 300; i++)
            do_wr(($urandom % 10) < 6, ($urandom % 10) < 8, 8'($urandom));
          do_wr(1'b0, 1'b0, 8'h00);
        end
        begin
          for (int i = 0; i < 220; i++)
            do_rd(($urandom % 10) < 4, ($urandom % 10) < 8, "R3 random order");
          do_rd(1'b0, 1'b0, "R3");
        end
      join
      repeat (8) @(negedge rd_clk);
      repeat (8) @(negedge wr_clk);
      chk("R4 quiescent wr_ready", 32'(wr_ready), 32'(mq.size() < fl));
      chk("R5 quiescent wr_afull", 32'(wr_afull), 32'(mq.size() >= afl));
      @(negedge rd_clk);
      chk("R6 quiescent rd_valid", 32'(rd_valid), 32'(mq.size() > 0));
      chk("R7 quiescent rd_aempty", 32'(rd_aempty), 32'(mq.size() <= ael));
      for (int i = 0; i < 40 && mq.size() > 0; i++) do_rd(1'b1, 1'b1, "R3 drain");
      do_rd(1'b0, 1'b0, "R3");
      chk("R3 drained", 32'(mq.size()), 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule